// File: doc/BRIEF.md
# Oversampled Serial Receiver with Four-Character Buffer

This block receives asynchronous serial characters from a single data line and holds them for a host. A baud-rate enable arrives as an input that pulses sixteen times per bit; the block finds the start bit, checks it at mid-bit, and then samples the data bits, an optional parity bit and the stop bit. Completed characters enter a three-entry FIFO. A fourth character can wait in a holding slot behind the FIFO, so four characters can be stored before any is lost. Each stored character carries its own parity, framing and break flags.

The host reads the character at the head of the FIFO with a one-cycle read strobe. It controls the receiver through single-cycle commands: enable, disable, receiver reset, error-status reset, and set or clear of a request-to-send output. Static configuration inputs select the character length, the parity, how errors are reported (per character or accumulated), which condition drives the interrupt output, and whether request-to-send is dropped automatically when the FIFO fills.

Top module: `serial_rx_quad`

## Requirements
- R1: After reset, rdy_o, full_o, ovr_o, perr_o, ferr_o, brk_o, irq_o and rts_o are all 0, and the receiver is disabled.
- R2: A low line is confirmed as a start bit 8 ticks after it is detected. Data bits are then sampled every 16 ticks, least significant bit first. cfg_bits_i values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits of rd_data_o above the character length read 0.
- R3: With cfg_par_en_i=1, one parity bit follows the data. It is even parity when cfg_par_odd_i=0 and odd parity when it is 1. A mismatch sets the per-character parity flag.
- R4: The FIFO holds three characters, and full_o is 1 exactly when it holds three. A fourth character waits in a holding slot and moves into the FIFO when a read frees a place. If a character completes while the FIFO is full and the holding slot is occupied, the new character replaces the waiting one and ovr_o becomes 1.
- R5: Command op 4 (error reset) clears ovr_o and the accumulated error flags. ovr_o is otherwise sticky.
- R6: irq_o equals rdy_o when cfg_irq_full_i=0 and full_o when it is 1. rdy_o is 1 when the FIFO is not empty.
- R7: Command op 5 sets rts_o and op 6 clears it. With cfg_rts_auto_i=1, rts_o drops to 0 in the same cycle the FIFO count reaches three, and it stays 0 until op 5 is issued.
- R8: Op 1 enables the receiver and op 2 disables it. While disabled, completed characters are not stored, but their framing, parity and break conditions still reach the accumulated flags.
- R9: A break is a character whose data bits, parity bit (if enabled) and stop bit are all 0. It is stored with its break and framing flags set. The receiver then waits for the line to go high, so only one break character is stored per low period.
- R10: With cfg_block_err_i=0, perr_o, ferr_o and brk_o show the flags of the head character (0 when the FIFO is empty) and change with each read. With cfg_block_err_i=1, they show the OR over all characters since the last error reset or receiver reset.
- R11: Command op 3 (receiver reset) empties the FIFO and the holding slot, clears ovr_o and the accumulated flags, and disables the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Enable pulse at 16 times the bit rate |
| rxd_i | input | 1 | Serial data line, idle high |
| cfg_bits_i | input | 2 | Data bits minus five |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| cfg_block_err_i | input | 1 | Accumulated error reporting when 1 |
| cfg_irq_full_i | input | 1 | Interrupt follows full when 1, ready when 0 |
| cfg_rts_auto_i | input | 1 | Drop request-to-send when the FIFO fills |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code: 1 enable, 2 disable, 3 receiver reset, 4 error reset, 5 RTS on, 6 RTS off |
| rd_en_i | input | 1 | Read strobe, removes the head character |
| rd_data_o | output | 8 | Head character |
| rdy_o | output | 1 | FIFO not empty |
| full_o | output | 1 | FIFO holds three characters |
| ovr_o | output | 1 | Overrun status |
| perr_o | output | 1 | Parity error status |
| ferr_o | output | 1 | Framing error status |
| brk_o | output | 1 | Received break status |
| irq_o | output | 1 | Selected interrupt condition |
| rts_o | output | 1 | Request-to-send, active high |

## Verification
The assertions assume that cfg_rts_auto_i changes only while the FIFO is not filling, and that commands are single-cycle strobes whose codes are in the table. The bench changes configuration only while the line is idle and the FIFO is in a known state, and it issues each command for exactly one cycle. The overrun and auto-RTS properties compare state across one clock edge. They assume that a read strobe is never given in the same cycle as the character that overflows the FIFO, and the bench reads only after a frame has ended.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } srx_char_t;

    typedef enum logic [2:0] {
        SR_IDLE  = 3'd0,
        SR_START = 3'd1,
        SR_DATA  = 3'd2,
        SR_PAR   = 3'd3,
        SR_STOP  = 3'd4,
        SR_BRKW  = 3'd5
    } srx_state_e;

    localparam logic [2:0] OP_RX_ON   = 3'd1;
    localparam logic [2:0] OP_RX_OFF  = 3'd2;
    localparam logic [2:0] OP_RX_RST  = 3'd3;
    localparam logic [2:0] OP_ERR_RST = 3'd4;
    localparam logic [2:0] OP_RTS_ON  = 3'd5;
    localparam logic [2:0] OP_RTS_OFF = 3'd6;
endpackage

// File: rtl/srx_deframer.sv
module srx_deframer
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            rxd_i,
    input  logic [1:0]      cfg_bits_i,
    input  logic            cfg_par_en_i,
    input  logic            cfg_par_odd_i,
    output logic            done_o,
    output srx_char_t       chr_o
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(CHAR_W);
    localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
    localparam logic [IW-1:0] MIN_LAST = IW'(CHAR_W - 4);

    typedef struct packed {
        srx_state_e        st;
        logic [CW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic [CHAR_W-1:0] sh;
        logic              parb;
        logic [1:0]        sync;
        logic              done;
        srx_char_t         chr;
    } df_t;

    df_t q, d;
    logic          rx;
    logic [IW-1:0] last_idx;
    logic          brk_now;

    assign rx       = q.sync[1];
    assign last_idx = MIN_LAST + IW'(cfg_bits_i);

    always_comb begin
        d       = q;
        d.sync  = {q.sync[0], rxd_i};
        d.done  = 1'b0;
        brk_now = 1'b0;
        case (q.st)
            SR_IDLE: begin
                if (tick_i && !rx) begin
                    d.st  = SR_START;
                    d.cnt = '0;
                    d.sh  = '0;
                    d.parb = 1'b0;
                end
            end
            SR_START: begin
                if (tick_i) begin
                    if (q.cnt == MID_CNT) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = rx ? SR_IDLE : SR_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            SR_DATA: begin
                if (tick_i) begin
                    if (q.cnt == LAST_CNT) begin
                        d.cnt        = '0;
                        d.sh[q.idx]  = rx;
                        if (q.idx == last_idx) begin
                            d.st = cfg_par_en_i ? SR_PAR : SR_STOP;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            SR_PAR: begin
                if (tick_i) begin
                    if (q.cnt == LAST_CNT) begin
                        d.cnt  = '0;
                        d.parb = rx;
                        d.st   = SR_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            SR_STOP: begin
                if (tick_i) begin
                    if (q.cnt == LAST_CNT) begin
                        brk_now     = !rx && (q.sh == '0) && !(cfg_par_en_i && q.parb);
                        d.cnt       = '0;
                        d.done      = 1'b1;
                        d.chr.data  = q.sh;
                        d.chr.ferr  = !rx;
                        d.chr.brk   = brk_now;
                        d.chr.perr  = cfg_par_en_i && (q.parb != ((^q.sh) ^ cfg_par_odd_i));
                        d.st        = brk_now ? SR_BRKW : SR_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            SR_BRKW: begin
                if (rx) begin
                    d.st = SR_IDLE;
                end
            end
            default: d.st = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign chr_o  = q.chr;
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush_i,
    input  logic                          push_i,
    input  logic                          pop_i,
    input  srx_char_t                     din_i,
    output srx_char_t                     dout_o,
    output logic [$clog2(DEPTH+1)-1:0]    count_o
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0]   LAST_PTR = PW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

    typedef struct packed {
        srx_char_t [DEPTH-1:0] mem;
        logic [PW-1:0]         rd;
        logic [PW-1:0]         wr;
        logic [CNTW-1:0]       cnt;
    } ff_t;

    ff_t  q, d;
    logic do_pop, do_push;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        do_pop  = pop_i && (q.cnt != '0);
        do_push = push_i && ((q.cnt != FULL_CNT) || do_pop);
        if (flush_i) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wr] = din_i;
                d.wr        = step(q.wr);
            end
            if (do_pop) begin
                d.rd = step(q.rd);
            end
            d.cnt = q.cnt + CNTW'(do_push) - CNTW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dout_o  = q.mem[q.rd];
    assign count_o = q.cnt;
endmodule

// File: rtl/serial_rx_quad.sv
module serial_rx_quad
    import srx_pkg::*;
#(
    parameter int FIFO_DEPTH = 3,
    parameter int OSR        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16_i,
    input  logic              rxd_i,
    input  logic [1:0]        cfg_bits_i,
    input  logic              cfg_par_en_i,
    input  logic              cfg_par_odd_i,
    input  logic              cfg_block_err_i,
    input  logic              cfg_irq_full_i,
    input  logic              cfg_rts_auto_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic              rd_en_i,
    output logic [CHAR_W-1:0] rd_data_o,
    output logic              rdy_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              perr_o,
    output logic              ferr_o,
    output logic              brk_o,
    output logic              irq_o,
    output logic              rts_o
);
    localparam int CNTW = $clog2(FIFO_DEPTH + 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(FIFO_DEPTH);

    typedef struct packed {
        logic      en;
        logic      pend_v;
        srx_char_t pend;
        logic      ovr;
        logic      acc_perr;
        logic      acc_ferr;
        logic      acc_brk;
        logic      rts;
    } top_t;

    top_t            q, d;
    logic            sr_done;
    srx_char_t       sr_chr;
    srx_char_t       head;
    srx_char_t       push_chr;
    logic [CNTW-1:0] fcnt;
    logic            push, pop, flush, room, take, fifo_full;
    int              cnt_next;
    logic            rx_en_w;

    srx_deframer #(.OSR(OSR)) u_deframer (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick16_i),
        .rxd_i         (rxd_i),
        .cfg_bits_i    (cfg_bits_i),
        .cfg_par_en_i  (cfg_par_en_i),
        .cfg_par_odd_i (cfg_par_odd_i),
        .done_o        (sr_done),
        .chr_o         (sr_chr)
    );

    srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .push_i  (push),
        .pop_i   (pop),
        .din_i   (push_chr),
        .dout_o  (head),
        .count_o (fcnt)
    );

    assign fifo_full = (fcnt == FULL_CNT);
    assign pop       = rd_en_i && (fcnt != '0);
    assign room      = !fifo_full || pop;
    assign take      = sr_done && q.en;

    always_comb begin
        d        = q;
        push     = 1'b0;
        flush    = 1'b0;
        push_chr = q.pend;

        // the holding slot drains first; a new character follows it
        if (q.pend_v && room) begin
            push     = 1'b1;
            push_chr = q.pend;
            d.pend_v = take;
            if (take) begin
                d.pend = sr_chr;
            end
        end else if (take && room) begin
            push     = 1'b1;
            push_chr = sr_chr;
        end else if (take) begin
            d.pend   = sr_chr;
            d.pend_v = 1'b1;
            if (q.pend_v) begin
                d.ovr = 1'b1;
            end
        end

        if (sr_done) begin
            d.acc_perr = q.acc_perr | sr_chr.perr;
            d.acc_ferr = q.acc_ferr | sr_chr.ferr;
            d.acc_brk  = q.acc_brk  | sr_chr.brk;
        end

        if (cmd_valid_i) begin
            case (cmd_op_i)
                OP_RX_ON:   d.en  = 1'b1;
                OP_RX_OFF:  d.en  = 1'b0;
                OP_RTS_ON:  d.rts = 1'b1;
                OP_RTS_OFF: d.rts = 1'b0;
                OP_ERR_RST: begin
                    d.ovr      = 1'b0;
                    d.acc_perr = 1'b0;
                    d.acc_ferr = 1'b0;
                    d.acc_brk  = 1'b0;
                end
                OP_RX_RST: begin
                    d.en       = 1'b0;
                    d.pend_v   = 1'b0;
                    d.ovr      = 1'b0;
                    d.acc_perr = 1'b0;
                    d.acc_ferr = 1'b0;
                    d.acc_brk  = 1'b0;
                    flush      = 1'b1;
                    push       = 1'b0;
                end
                default: ;
            endcase
        end

        cnt_next = flush ? 0 : (int'(fcnt) + int'(push && room) - int'(pop));
        if (cfg_rts_auto_i && !fifo_full && (cnt_next == FIFO_DEPTH)) begin
            d.rts = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_en_w   = q.en;
    assign rd_data_o = head.data;
    assign rdy_o     = (fcnt != '0);
    assign full_o    = fifo_full;
    assign ovr_o     = q.ovr;
    assign perr_o    = cfg_block_err_i ? q.acc_perr : (rdy_o && head.perr);
    assign ferr_o    = cfg_block_err_i ? q.acc_ferr : (rdy_o && head.ferr);
    assign brk_o     = cfg_block_err_i ? q.acc_brk  : (rdy_o && head.brk);
    assign irq_o     = cfg_irq_full_i ? fifo_full : rdy_o;
    assign rts_o     = q.rts;
endmodule

// File: rtl/srx_checker.sv
module srx_checker
    import srx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rdy,
    input logic       full,
    input logic       ovr,
    input logic       irq,
    input logic       rts,
    input logic       cfg_rts_auto,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       rx_en
);
    a_r4_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(full));

    a_r4_full_implies_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> rdy);

    a_r5_err_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ERR_RST) |=> !ovr);

    a_r6_irq_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> !irq);

    a_r7_rts_auto_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(full) && $past(cfg_rts_auto)) |-> !rts);

    a_r8_load_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(rx_en));

    a_r11_rx_reset_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RX_RST) |=> (!rdy && !ovr && !rx_en));
endmodule

bind serial_rx_quad srx_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rdy          (rdy_o),
    .full         (full_o),
    .ovr          (ovr_o),
    .irq          (irq_o),
    .rts          (rts_o),
    .cfg_rts_auto (cfg_rts_auto_i),
    .cmd_valid    (cmd_valid_i),
    .cmd_op       (cmd_op_i),
    .rx_en        (rx_en_w)
);

// File: tb/serial_rx_quad_bench.sv
`timescale 1ns/1ps
module serial_rx_quad_bench;
    localparam int BITCLK = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_bits = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_block_err = 1'b0;
    logic       cfg_irq_full = 1'b0;
    logic       cfg_rts_auto = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rdy, full, ovr, perr, ferr, brk, irq, rts;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    serial_rx_quad u_serial_rx_quad (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick16_i        (tick16),
        .rxd_i           (rxd),
        .cfg_bits_i      (cfg_bits),
        .cfg_par_en_i    (cfg_par_en),
        .cfg_par_odd_i   (cfg_par_odd),
        .cfg_block_err_i (cfg_block_err),
        .cfg_irq_full_i  (cfg_irq_full),
        .cfg_rts_auto_i  (cfg_rts_auto),
        .cmd_valid_i     (cmd_valid),
        .cmd_op_i        (cmd_op),
        .rd_en_i         (rd_en),
        .rd_data_o       (rd_data),
        .rdy_o           (rdy),
        .full_o          (full),
        .ovr_o           (ovr),
        .perr_o          (perr),
        .ferr_o          (ferr),
        .brk_o           (brk),
        .irq_o           (irq),
        .rts_o           (rts)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick16 = ~tick16;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic send_frame(input logic [7:0] data, input int nbits, input bit par_en,
                              input bit par_odd, input bit bad_par, input bit stop_val,
                              input int extra_low);
        logic [7:0] m;
        m = data & 8'((1 << nbits) - 1);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rxd = m[i];
            repeat (BITCLK) @(negedge clk);
        end
        if (par_en) begin
            rxd = (^m) ^ par_odd ^ bad_par;
            repeat (BITCLK) @(negedge clk);
        end
        rxd = stop_val;
        repeat (BITCLK) @(negedge clk);
        if (extra_low > 0) begin
            rxd = 1'b0;
            repeat (extra_low) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send8(input logic [7:0] data);
        send_frame(data, 8, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    endtask

    task automatic read_expect(input string tag, input int exp);
        @(negedge clk);
        chk({tag, " rdy before read"}, int'(rdy), 1);
        chk({tag, " data"}, int'(rd_data), exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 rdy", int'(rdy), 0);
        chk("R1 full", int'(full), 0);
        chk("R1 ovr", int'(ovr), 0);
        chk("R1 perr", int'(perr), 0);
        chk("R1 ferr", int'(ferr), 0);
        chk("R1 brk", int'(brk), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 rts", int'(rts), 0);
        send8(8'h5A);
        chk("R1 disabled after reset stores nothing", int'(rdy), 0);
    endtask

    task automatic t_basic();
        cmd(3'd1);
        send8(8'hA5);
        chk("R6 irq follows rdy", int'(irq), 1);
        chk("R10 clean head ferr", int'(ferr), 0);
        read_expect("R2 8-bit A5", 8'hA5);
        send8(8'h3C);
        read_expect("R2 8-bit 3C", 8'h3C);
        chk("R2 empty after reads", int'(rdy), 0);
    endtask

    task automatic t_parity();
        cfg_bits = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send_frame(8'h13, 5, 1'b1, 1'b0, 1'b0, 1'b1, 0);
        send_frame(8'h0A, 5, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        @(negedge clk);
        chk("R3 even good perr", int'(perr), 0);
        read_expect("R2 5-bit 13", 8'h13);
        @(negedge clk);
        chk("R10 head advanced perr", int'(perr), 1);
        read_expect("R3 5-bit bad parity 0A", 8'h0A);
        cfg_bits = 2'd3; cfg_par_odd = 1'b1;
        send_frame(8'hC3, 8, 1'b1, 1'b1, 1'b0, 1'b1, 0);
        @(negedge clk);
        chk("R3 odd good perr", int'(perr), 0);
        read_expect("R3 odd C3", 8'hC3);
        cfg_bits = 2'd1; cfg_par_en = 1'b0;
        send_frame(8'hFF, 6, 1'b0, 1'b0, 1'b0, 1'b1, 0);
        read_expect("R2 6-bit upper bits zero", 8'h3F);
        cfg_bits = 2'd3; cfg_par_odd = 1'b0;
    endtask

    task automatic t_overrun();
        send8(8'h11);
        cfg_irq_full = 1'b1;
        @(negedge clk);
        chk("R6 irq follows full (not full)", int'(irq), 0);
        send8(8'h22);
        send8(8'h33);
        chk("R4 full at three", int'(full), 1);
        chk("R6 irq follows full", int'(irq), 1);
        send8(8'h44);
        chk("R4 fourth held no overrun", int'(ovr), 0);
        send8(8'h55);
        chk("R4 overrun on fifth", int'(ovr), 1);
        read_expect("R4 first", 8'h11);
        chk("R4 held char refills fifo", int'(full), 1);
        read_expect("R4 second", 8'h22);
        read_expect("R4 third", 8'h33);
        read_expect("R4 overwriting char", 8'h55);
        chk("R4 nothing more", int'(rdy), 0);
        chk("R5 ovr sticky", int'(ovr), 1);
        cmd(3'd4);
        chk("R5 error reset clears ovr", int'(ovr), 0);
        cfg_irq_full = 1'b0;
    endtask

    task automatic t_rts();
        cfg_rts_auto = 1'b1;
        cmd(3'd5);
        chk("R7 rts on", int'(rts), 1);
        send8(8'h01);
        send8(8'h02);
        chk("R7 rts kept below full", int'(rts), 1);
        send8(8'h03);
        chk("R7 rts dropped at full", int'(rts), 0);
        read_expect("R7 drain 1", 8'h01);
        chk("R7 rts stays low", int'(rts), 0);
        cmd(3'd5);
        chk("R7 rts on again", int'(rts), 1);
        cmd(3'd6);
        chk("R7 rts off command", int'(rts), 0);
        read_expect("R7 drain 2", 8'h02);
        read_expect("R7 drain 3", 8'h03);
        cfg_rts_auto = 1'b0;
    endtask

    task automatic t_break();
        send_frame(8'h00, 8, 1'b0, 1'b0, 1'b0, 1'b0, 3 * BITCLK);
        @(negedge clk);
        chk("R9 brk flag", int'(brk), 1);
        chk("R9 ferr flag", int'(ferr), 1);
        read_expect("R9 break data", 8'h00);
        chk("R9 only one break char", int'(rdy), 0);
        chk("R10 empty flags zero", int'(brk), 0);
        send_frame(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        @(negedge clk);
        chk("R9 nonzero framing not break", int'(brk), 0);
        chk("R9 nonzero framing ferr", int'(ferr), 1);
        read_expect("R9 framing char", 8'h81);
    endtask

    task automatic t_block();
        cfg_block_err = 1'b1; cfg_par_en = 1'b1;
        send_frame(8'h6E, 8, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        send_frame(8'h6F, 8, 1'b1, 1'b0, 1'b0, 1'b1, 0);
        read_expect("R10 block read 1", 8'h6E);
        read_expect("R10 block read 2", 8'h6F);
        @(negedge clk);
        chk("R10 block perr accumulated", int'(perr), 1);
        cmd(3'd4);
        chk("R5 block perr cleared", int'(perr), 0);
        cfg_par_en = 1'b0;
    endtask

    task automatic t_disabled();
        cmd(3'd2);
        send_frame(8'h55, 8, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        chk("R8 disabled not stored", int'(rdy), 0);
        chk("R8 disabled ferr seen", int'(ferr), 1);
        cmd(3'd4);
        cmd(3'd1);
        cfg_block_err = 1'b0;
    endtask

    task automatic t_rxreset();
        send8(8'h77);
        send8(8'h78);
        cmd(3'd3);
        chk("R11 fifo flushed", int'(rdy), 0);
        chk("R11 ovr clear", int'(ovr), 0);
        send8(8'h79);
        chk("R11 receiver disabled", int'(rdy), 0);
        cmd(3'd1);
        send8(8'h7A);
        read_expect("R11 after re-enable", 8'h7A);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_parity();
        t_overrun();
        t_rts();
        t_break();
        t_block();
        t_disabled();
        t_rxreset();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule